// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a processor's register bus and an eight-input successive-approximation converter. Software drives it through two 32-bit words. The control word holds the enable, the reference choice, the interrupt enable, the input selection and a clock divider. It also carries three action bits: a start bit that clears itself, a status bit that software clears by writing one, and a module reset. A second, read-only word returns the most recent result.

When software sets the start bit with the enable bit set, the block freezes the chosen input and the divider value. It then counts a fixed number of conversion-clock periods, each lasting `(div+1)*2` input clocks, and reads the converter's digital sample port on the last period. In that same cycle the start bit drops and the status bit rises. The interrupt line follows the status bit whenever interrupts are enabled. Software therefore needs only one register for the whole handshake: it writes start, polls or waits for the interrupt, writes the status bit back to clear it, and reads the data word.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control word (offset 0x00), the data word (offset 0x04) and `irq` are all 0. Any other offset reads as 0.
- R2: These control fields are written and read back at fixed positions: divider in bits 8:1, enable in bit 17, internal-reference select in bit 19 (also driven on `vref_int`), interrupt enable in bit 21, and input select in bits 26:24. Bits 27, 16, 0 and all other unlisted bits read 0.
- R3: A conversion lasts (RES_BITS+2)*(div+1)*2 input clocks, counted from the clock edge that accepts the start write. Bit 13 reads 1 for the whole conversion and 0 once it completes. The divider value is captured at start, so rewriting it mid-conversion does not change that conversion's length.
- R4: On completion, `sample_data` is stored right-aligned in the data word with the upper bits zero. In the same cycle bit 13 clears and status bit 18 sets.
- R5: Writing the control word with bit 18 = 1 clears the status bit. Writing bit 18 = 0 leaves it unchanged.
- R6: `irq` is 1 exactly when the status bit and the interrupt enable are both 1.
- R7: A start bit written together with enable = 0 is ignored: bit 13 reads 0 and no status follows. Writing enable = 0 during a conversion aborts it, and the data word and status are left untouched.
- R8: A control write with bit 16 = 1 returns every field to 0, aborts any conversion, and clears the status bit and the data word. Bit 16 always reads 0.
- R9: The input select is captured at start and shown on `sample_ch` for the whole conversion. A select written mid-conversion appears in the control word but does not change `sample_ch`.
- R10: A start bit written during a conversion neither restarts nor lengthens that conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sample_data | input | RES_BITS | Converter result, read on the last conversion period |
| sample_ch | output | 3 | Input being converted |
| vref_int | output | 1 | 1 selects the internal reference |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_wr` is a clean single-cycle strobe. They also assume that `sample_data` holds a settled value at the cycle the conversion completes, since nothing in the block checks the converter itself. The bench writes only at falling edges, so each write is seen by exactly one rising edge. It keeps `sample_data` constant across every conversion whose result it compares. Every wait is timed from the edge that accepted the start write, so bus latency never enters the expected conversion length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DIV_W = 8;
    localparam int CH_W  = 3;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_DATA = 8'h04;

    localparam int B_DIV_LO = 1;
    localparam int B_START  = 13;
    localparam int B_MRST   = 16;
    localparam int B_EN     = 17;
    localparam int B_STAT   = 18;
    localparam int B_VREF   = 19;
    localparam int B_IEN    = 21;
    localparam int B_CH_LO  = 24;

    typedef struct packed {
        logic             ien;
        logic             vref;
        logic             en;
        logic [CH_W-1:0]  ch;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.ien  = w[B_IEN];
        c.vref = w[B_VREF];
        c.en   = w[B_EN];
        c.ch   = w[B_CH_LO +: CH_W];
        c.div  = w[B_DIV_LO +: DIV_W];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c, input logic busy,
                                                 input logic stat);
        logic [31:0] w;
        w = '0;
        w[B_IEN]              = c.ien;
        w[B_VREF]             = c.vref;
        w[B_EN]               = c.en;
        w[B_STAT]             = stat;
        w[B_START]            = busy;
        w[B_CH_LO +: CH_W]    = c.ch;
        w[B_DIV_LO +: DIV_W]  = c.div;
        return w;
    endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = {div_q, 1'b1};
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
        end
    end

    // R3
    div_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= limit));

endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            abort,
    input  logic            tick,
    input  logic [CH_W-1:0] ch_in,
    output logic            busy,
    output logic            done,
    output logic [CH_W-1:0] conv_ch
);
    localparam int NPER   = RES_BITS + 2;
    localparam int TCNT_W = $clog2(NPER);
    localparam logic [TCNT_W-1:0] LAST = TCNT_W'(NPER - 1);

    logic [TCNT_W-1:0] tcnt_q;

    assign done = busy && tick && (tcnt_q == LAST) && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            tcnt_q  <= '0;
            conv_ch <= '0;
        end else if (abort) begin
            busy    <= 1'b0;
            tcnt_q  <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            tcnt_q  <= '0;
            conv_ch <= ch_in;
        end else if (busy && tick) begin
            if (tcnt_q == LAST) begin
                busy   <= 1'b0;
                tcnt_q <= '0;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    // R9
    ch_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(start)) |-> $stable(conv_ch));

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                busy,
    input  logic                done,
    input  logic [RES_BITS-1:0] sample_data,
    output logic                start,
    output logic                abort,
    output ctrl_t               ctrl,
    output logic                stat,
    output logic                irq
);
    logic                wr_ctrl;
    logic                mrst;
    logic [RES_BITS-1:0] data_q;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign mrst    = wr_ctrl && bus_wdata[B_MRST];
    assign start   = wr_ctrl && !mrst && bus_wdata[B_START] && bus_wdata[B_EN] && !busy;
    assign abort   = wr_ctrl && (mrst || !bus_wdata[B_EN]);
    assign irq     = stat && ctrl.ien;

    always_ff @(posedge clk) begin
        if (rst || mrst) begin
            ctrl   <= '0;
            stat   <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_from_word(bus_wdata);
            if (done) begin
                stat   <= 1'b1;
                data_q <= sample_data;
            end else if (wr_ctrl && bus_wdata[B_STAT]) begin
                stat <= 1'b0;
            end
        end
    end

    always_comb begin
        if (bus_addr == ADDR_W'(OFF_CTRL))
            bus_rdata = ctrl_to_word(ctrl, busy, stat);
        else if (bus_addr == ADDR_W'(OFF_DATA))
            bus_rdata = 32'(data_q);
        else
            bus_rdata = '0;
    end

    // R4
    stat_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat) |-> $past(busy));

    // R8
    mrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mrst) |-> (!stat && data_q == '0 && ctrl == '0));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [RES_BITS-1:0] sample_data,
    output logic [CH_W-1:0]     sample_ch,
    output logic                vref_int,
    output logic                irq
);
    ctrl_t ctrl;
    logic  start, abort, busy, done, tick, stat;

    adc_seq_regs #(.RES_BITS(RES_BITS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .sample_data(sample_data), .start(start), .abort(abort), .ctrl(ctrl),
        .stat(stat), .irq(irq)
    );

    adc_seq_clkdiv u_div (
        .clk(clk), .rst(rst), .load(start),
        .div_in(bus_wdata[B_DIV_LO +: DIV_W]), .run(busy), .tick(tick)
    );

    adc_seq_engine #(.RES_BITS(RES_BITS)) u_eng (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .tick(tick),
        .ch_in(bus_wdata[B_CH_LO +: CH_W]), .busy(busy), .done(done),
        .conv_ch(sample_ch)
    );

    assign vref_int = ctrl.vref;

    // R7
    busy_en_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> ctrl.en);

    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat && ctrl.ien));

endmodule

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int RES        = 10;
    localparam int NPER       = RES + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [RES-1:0] sample_data = '0;
    logic [2:0]    sample_ch;
    logic          vref_int;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_seq_top #(.RES_BITS(RES), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_data(sample_data),
        .sample_ch(sample_ch), .vref_int(vref_int), .irq(irq)
    );

    function automatic logic [31:0] mk(input logic en, input logic ien, input logic vr,
                                       input logic [3:0] ch, input logic [7:0] dv,
                                       input logic go, input logic clr, input logic mr);
        logic [31:0] w;
        w = '0;
        w[17] = en; w[21] = ien; w[19] = vr; w[27:24] = ch; w[8:1] = dv;
        w[13] = go; w[18] = clr; w[16] = mr;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); check("R1 ctrl reset", d, 0);
        rd(8'h04, d); check("R1 data reset", d, 0);
        rd(8'h08, d); check("R1 unmapped", d, 0);
        check("R1 irq reset", 32'(irq), 0);
    endtask

    task automatic t_fields();
        logic [31:0] d;
        wr(8'h00, mk(1, 0, 1, 4'h5, 8'hA5, 0, 0, 0) | 32'h1);
        rd(8'h00, d);
        check("R2 fields", d, mk(1, 0, 1, 4'h5, 8'hA5, 0, 0, 0));
        check("R2 vref_int", 32'(vref_int), 1);
        wr(8'h00, mk(1, 1, 0, 4'hF, 8'h00, 0, 0, 0));
        rd(8'h00, d);
        check("R2 bit27 reads 0", d, mk(1, 1, 0, 4'h7, 8'h00, 0, 0, 0));
        check("R2 vref_int low", 32'(vref_int), 0);
    endtask

    task automatic t_conv();
        logic [31:0] d;
        int s;
        wr(8'h00, mk(0, 0, 0, 0, 0, 0, 0, 1));
        sample_data = 10'h2AB;
        wr(8'h00, mk(1, 0, 0, 4'h2, 8'h00, 1, 0, 0));
        s = cyc;
        check("R9 sample_ch", 32'(sample_ch), 2);
        wait_to(s + NPER*2 - 1);
        rd(8'h00, d);
        check("R3 busy before end", 32'(d[13]), 1);
        check("R4 status before end", 32'(d[18]), 0);
        wait_to(s + NPER*2);
        rd(8'h00, d);
        check("R3 start clears at end", 32'(d[13]), 0);
        check("R4 status sets at end", 32'(d[18]), 1);
        rd(8'h04, d);
        check("R4 data captured", d, 32'h2AB);
        check("R6 irq off without ien", 32'(irq), 0);
        wr(8'h00, mk(1, 1, 0, 4'h2, 8'h00, 0, 0, 0));
        check("R6 irq with ien", 32'(irq), 1);
        rd(8'h00, d);
        check("R5 status kept on 0 write", 32'(d[18]), 1);
        wr(8'h00, mk(1, 1, 0, 4'h2, 8'h00, 0, 1, 0));
        rd(8'h00, d);
        check("R5 status cleared", 32'(d[18]), 0);
        check("R6 irq drops", 32'(irq), 0);
    endtask

    task automatic t_div_mid();
        logic [31:0] d;
        int s;
        sample_data = 10'h3C1;
        wr(8'h00, mk(1, 0, 0, 4'h1, 8'h03, 1, 0, 0));
        s = cyc;
        wait_to(s + 10);
        wr(8'h00, mk(1, 0, 0, 4'h6, 8'h00, 1, 0, 0));
        rd(8'h00, d);
        check("R9 ctrl shows new ch", 32'(d[26:24]), 6);
        check("R9 sample_ch held", 32'(sample_ch), 1);
        wait_to(s + NPER*8 - 1);
        rd(8'h00, d);
        check("R3 R10 still busy (div latched)", 32'(d[13]), 1);
        wait_to(s + NPER*8);
        rd(8'h00, d);
        check("R3 R10 done at latched length", 32'(d[18]), 1);
        rd(8'h04, d);
        check("R4 data div3", d, 32'h3C1);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        int s;
        wr(8'h00, mk(0, 0, 0, 0, 0, 0, 1, 0));
        wr(8'h00, mk(0, 0, 0, 4'h3, 8'h00, 1, 0, 0));
        s = cyc;
        rd(8'h00, d);
        check("R7 start ignored when disabled", 32'(d[13]), 0);
        wait_to(s + NPER*2 + 4);
        rd(8'h00, d);
        check("R7 no status when disabled", 32'(d[18]), 0);
        sample_data = 10'h011;
        wr(8'h00, mk(1, 0, 0, 4'h3, 8'h00, 1, 0, 0));
        s = cyc;
        wait_to(s + 5);
        wr(8'h00, mk(0, 0, 0, 4'h3, 8'h00, 0, 0, 0));
        rd(8'h00, d);
        check("R7 abort clears start", 32'(d[13]), 0);
        wait_to(s + NPER*2 + 4);
        rd(8'h00, d);
        check("R7 abort no status", 32'(d[18]), 0);
        rd(8'h04, d);
        check("R7 abort keeps data", d, 32'h3C1);
    endtask

    task automatic t_mrst();
        logic [31:0] d;
        int s;
        wr(8'h00, mk(1, 1, 1, 4'h4, 8'h00, 1, 0, 0));
        s = cyc;
        wait_to(s + NPER*2);
        check("R6 irq after conversion", 32'(irq), 1);
        wr(8'h00, mk(1, 1, 1, 4'h4, 8'h00, 1, 0, 0));
        s = cyc;
        wait_to(s + 6);
        wr(8'h00, mk(1, 1, 1, 4'h4, 8'h10, 1, 0, 1));
        rd(8'h00, d);
        check("R8 ctrl cleared", d, 0);
        rd(8'h04, d);
        check("R8 data cleared", d, 0);
        check("R8 irq cleared", 32'(irq), 0);
        wait_to(s + NPER*2 + 4);
        rd(8'h00, d);
        check("R8 conversion aborted", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_conv();
        t_div_mid();
        t_disabled();
        t_mrst();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule